// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a small bank of interrupt sources (sixteen by default) and turns their activity into requests for a downstream presentation unit. Each source is fixed at elaboration time as either level-sensitive or message-signaled. Each source holds a target server, a priority and a saved priority, and it keeps four status flags: asserted, sent, rejected and masked-pending. A request names the source by its global number, which is the local index plus a fixed base. Requests carry the source's server and priority. The presentation unit answers with reject and end-of-interrupt notifications, which name a global number. It can also ask for a resend sweep, which walks every source in turn, one per cycle, and replays what was turned away.

The two source types keep different state. A level source follows its input pin every cycle in the asserted flag and uses the sent flag to avoid duplicates. It evaluates its send condition when the input rises, when it is configured, and when the sweep visits it. A message source fires on a rising edge of its pin. If it is masked it latches masked-pending. If it is turned away it latches rejected. It is replayed only by a configuration write or by a sweep visit. A priority of all ones (0xFF) means masked.

All requests leave through one valid/ready port, which is managed by the state machine `ARB_IDLE`/`ARB_OFFER`. The transition pick goes from `ARB_IDLE` to `ARB_OFFER` and latches the lowest queued index. The transition handshake goes from `ARB_OFFER` back to `ARB_IDLE` and retires that source. The sweep is a second state machine, `SWP_IDLE`/`SWP_RUN`. The transition start goes from `SWP_IDLE` to `SWP_RUN`. In `SWP_RUN`, the transition advance moves to the next index and the transition restart goes back to index 0. The transition done goes from `SWP_RUN` to `SWP_IDLE`. A read port shows any source's settings and status.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset every source reads server 0, priority 0xFF, saved priority 0xFF and status 0, and no request is offered. The status bits are: bit0 asserted, bit1 sent, bit2 rejected, bit3 masked-pending.
- R2: A request's number is BASE plus the local index. A reject or end-of-interrupt notification whose number lies outside BASE to BASE+N-1 changes no source.
- R3: A rising edge on a message source's input with a priority other than 0xFF produces exactly one request carrying that source's server and priority. Holding the input high produces no further request.
- R4: A rising edge on a message source whose priority is 0xFF sets masked-pending (status bit3) and produces no request.
- R5: A configuration write stores server, priority and saved priority. If the source is a message source with masked-pending set and the new priority is not 0xFF, the write clears masked-pending and produces a request.
- R6: A level source's asserted bit (bit0) follows its input. The source requests when it is asserted, its priority is not 0xFF and sent (bit1) is clear. A rising input, a configuration write or a sweep visit triggers this check. Sending sets sent, and no duplicate request follows while sent stays set.
- R7: A reject sets rejected (bit2) on a message source and clears sent on a level source. Neither produces a request by itself.
- R8: An end-of-interrupt clears sent on a level source without a new request. On a message source it changes no status and produces no request.
- R9: A resend sweep visits the sources one per cycle. A visited message source with rejected set clears the flag and requests again unless its priority is 0xFF. A visited level source re-checks its send condition.
- R10: A resend request that arrives while a sweep is running causes a further full sweep once the current sweep ends.
- R11: While a request waits for ready, its valid, number, server and priority stay unchanged. When several sources are queued, the lowest index is offered first.
- R12: When a reject and a sweep visit hit the same message source in the same cycle, the visit acts on the flags from before the reject. The source is not resent, and its rejected flag ends set.
- R13: When a configuration write and a message input edge hit the same source in the same cycle, the edge is judged against the newly written priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N | Interrupt input pins, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority (all ones = masked) |
| cfg_saved | input | PRIO_W | New saved priority |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | GNUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt notification strobe |
| eoi_num | input | GNUM_W | Global number being completed |
| rsnd_valid | input | 1 | Resend sweep request |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Presentation unit takes the request |
| req_num | output | GNUM_W | Global source number of the request |
| req_server | output | SRV_W | Target server of the request |
| req_prio | output | PRIO_W | Priority of the request |
| qry_idx | input | IDX_W | Local index to read back |
| qry_server | output | SRV_W | Server of the selected source |
| qry_prio | output | PRIO_W | Priority of the selected source |
| qry_saved | output | PRIO_W | Saved priority of the selected source |
| qry_status | output | 4 | Status flags of the selected source |

## Verification
Two functions can fall on the same source in the same cycle: a reject notification and the sweep's visit. A configuration write and an input edge can also coincide. The bench starts a sweep and counts cycles so that a reject for message source 3 arrives in the cycle the sweep visits index 3. Correct behaviour is judged by the absence of a request through the rest of the sweep, by the rejected flag reading set afterwards, and by a second sweep that then replays the source. The write-plus-edge case drives both in one cycle on a masked source and expects a request at the new priority, with masked-pending left clear.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
    typedef enum logic {ARB_IDLE, ARB_OFFER} arb_state_e;
    typedef enum logic {SWP_IDLE, SWP_RUN} swp_state_e;
    localparam int ST_W        = 4;
    localparam int ST_ASSERTED = 0;
    localparam int ST_SENT     = 1;
    localparam int ST_REJECTED = 2;
    localparam int ST_MPEND    = 3;
endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SRV_W    = 4,
    parameter int PRIO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              visit,
    input  logic              grant,
    output logic              queued,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] saved,
    output logic [ST_W-1:0]   status
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

    logic              smp, sent, rejected, mpend;
    logic              sent_n, rej_n, mp_n, q_n, rise;
    logic [SRV_W-1:0]  srv_n;
    logic [PRIO_W-1:0] prio_n, saved_n;

    always_comb begin
        srv_n   = cfg_hit ? cfg_server : server;
        prio_n  = cfg_hit ? cfg_prio   : prio;
        saved_n = cfg_hit ? cfg_saved  : saved;
        q_n     = grant ? 1'b0 : queued;
        sent_n  = sent;
        rej_n   = rejected;
        mp_n    = mpend;
        rise    = pin & ~smp;
        if (IS_LEVEL) begin
            if (rej_hit || eoi_hit) sent_n = 1'b0;
            if ((rise || cfg_hit || visit) && pin && !sent_n && prio_n != MASKED) begin
                sent_n = 1'b1;
                q_n    = 1'b1;
            end
        end else begin
            if (cfg_hit && mpend && cfg_prio != MASKED) begin
                mp_n = 1'b0;
                q_n  = 1'b1;
            end
            if (visit && rejected) begin
                rej_n = 1'b0;
                if (prio_n != MASKED) q_n = 1'b1;
            end
            if (rej_hit) rej_n = 1'b1;
            if (rise) begin
                if (prio_n == MASKED) mp_n = 1'b1;
                else                  q_n  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp      <= 1'b0;
            sent     <= 1'b0;
            rejected <= 1'b0;
            mpend    <= 1'b0;
            queued   <= 1'b0;
            server   <= '0;
            prio     <= MASKED;
            saved    <= MASKED;
        end else begin
            smp      <= pin;
            sent     <= sent_n;
            rejected <= rej_n;
            mpend    <= mp_n;
            queued   <= q_n;
            server   <= srv_n;
            prio     <= prio_n;
            saved    <= saved_n;
        end
    end

    always_comb begin
        status              = '0;
        status[ST_ASSERTED] = IS_LEVEL ? smp : 1'b0;
        status[ST_SENT]     = sent;
        status[ST_REJECTED] = rejected;
        status[ST_MPEND]    = mpend;
    end

    // R6: a level source only marks itself sent while asserted and unmasked
    assert_lvl_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_LEVEL && $rose(sent)) |-> (smp && prio != MASKED));
    // R4: masked-pending only latches on a masked message source
    assert_mpend_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_LEVEL && $rose(mpend)) |-> (prio == MASKED));
    // R5: leaving masked-pending always queues a request
    assert_unmask_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_LEVEL && $fell(mpend)) |-> queued);
endmodule

// File: rtl/irqsrc_sweep.sv
module irqsrc_sweep
    import irqsrc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [N-1:0] visit
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    swp_state_e       st, st_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             again, again_n;

    always_comb begin
        st_n    = st;
        idx_n   = idx;
        again_n = again;
        unique case (st)
            SWP_IDLE: begin
                if (start) begin
                    st_n  = SWP_RUN;
                    idx_n = '0;
                end
            end
            SWP_RUN: begin
                if (idx == LAST) begin
                    if (again || start) begin
                        idx_n   = '0;
                        again_n = 1'b0;
                    end else begin
                        st_n = SWP_IDLE;
                    end
                end else begin
                    idx_n = idx + 1'b1;
                    if (start) again_n = 1'b1;
                end
            end
            default: st_n = SWP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SWP_IDLE;
            idx   <= '0;
            again <= 1'b0;
        end else begin
            st    <= st_n;
            idx   <= idx_n;
            again <= again_n;
        end
    end

    always_comb begin
        visit = '0;
        unique case (st)
            SWP_IDLE: visit = '0;
            SWP_RUN:  visit[idx] = 1'b1;
            default:  visit = '0;
        endcase
    end

    // R9: the sweep advances one source per cycle
    assert_sweep_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SWP_RUN && idx != LAST) |=> (st == SWP_RUN && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/irqsrc_arb.sv
module irqsrc_arb
    import irqsrc_pkg::*;
#(
    parameter int          N      = 16,
    parameter int          SRV_W  = 4,
    parameter int          PRIO_W = 8,
    parameter int          GNUM_W = 16,
    parameter int unsigned BASE   = 4096
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 pend,
    input  logic [N-1:0][SRV_W-1:0]      srv_a,
    input  logic [N-1:0][PRIO_W-1:0]     prio_a,
    input  logic                         req_ready,
    output logic                         req_valid,
    output logic [GNUM_W-1:0]            req_num,
    output logic [SRV_W-1:0]             req_server,
    output logic [PRIO_W-1:0]            req_prio,
    output logic [N-1:0]                 grant
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    arb_state_e       st, st_n;
    logic [IDX_W-1:0] pick, held;
    logic             any;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ARB_IDLE:  if (any)       st_n = ARB_OFFER;
            ARB_OFFER: if (req_ready) st_n = ARB_IDLE;
            default:                  st_n = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ARB_IDLE;
            held       <= '0;
            req_num    <= '0;
            req_server <= '0;
            req_prio   <= '0;
        end else begin
            st <= st_n;
            if (st == ARB_IDLE && any) begin
                held       <= pick;
                req_num    <= GNUM_W'(BASE) + GNUM_W'(pick);
                req_server <= srv_a[pick];
                req_prio   <= prio_a[pick];
            end
        end
    end

    always_comb begin
        req_valid = 1'b0;
        grant     = '0;
        unique case (st)
            ARB_IDLE: req_valid = 1'b0;
            ARB_OFFER: begin
                req_valid = 1'b1;
                if (req_ready) grant[held] = 1'b1;
            end
            default: req_valid = 1'b0;
        endcase
    end

    // R11: a stalled request keeps its fields
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_num)
                                       && $stable(req_server) && $stable(req_prio)));
    // R11: at most one source retired per handshake
    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/irqsrc_ctrl.sv
module irqsrc_ctrl
    import irqsrc_pkg::*;
#(
    parameter int          N          = 16,
    parameter logic [N-1:0] LEVEL_MASK = 16'hFF00,
    parameter int          SRV_W      = 4,
    parameter int          PRIO_W     = 8,
    parameter int          GNUM_W     = 16,
    parameter int unsigned BASE       = 4096,
    localparam int         IDX_W      = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_in,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              rej_valid,
    input  logic [GNUM_W-1:0] rej_num,
    input  logic              eoi_valid,
    input  logic [GNUM_W-1:0] eoi_num,
    input  logic              rsnd_valid,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [GNUM_W-1:0] req_num,
    output logic [SRV_W-1:0]  req_server,
    output logic [PRIO_W-1:0] req_prio,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [SRV_W-1:0]  qry_server,
    output logic [PRIO_W-1:0] qry_prio,
    output logic [PRIO_W-1:0] qry_saved,
    output logic [ST_W-1:0]   qry_status
);
    logic [N-1:0]             pend, grant, visit;
    logic [N-1:0][SRV_W-1:0]  srv_a;
    logic [N-1:0][PRIO_W-1:0] prio_a, saved_a;
    logic [N-1:0][ST_W-1:0]   stat_a;
    logic [GNUM_W-1:0]        rej_off, eoi_off;
    logic                     rej_ok, eoi_ok;

    assign rej_off = rej_num - GNUM_W'(BASE);
    assign eoi_off = eoi_num - GNUM_W'(BASE);
    assign rej_ok  = rej_valid && (rej_num >= GNUM_W'(BASE)) && (rej_off < GNUM_W'(N));
    assign eoi_ok  = eoi_valid && (eoi_num >= GNUM_W'(BASE)) && (eoi_off < GNUM_W'(N));

    for (genvar i = 0; i < N; i++) begin : g_slot
        irqsrc_slot #(
            .IS_LEVEL (LEVEL_MASK[i]),
            .SRV_W    (SRV_W),
            .PRIO_W   (PRIO_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (src_in[i]),
            .cfg_hit    (cfg_we && cfg_idx == IDX_W'(i)),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .cfg_saved  (cfg_saved),
            .rej_hit    (rej_ok && rej_off[IDX_W-1:0] == IDX_W'(i)),
            .eoi_hit    (eoi_ok && eoi_off[IDX_W-1:0] == IDX_W'(i)),
            .visit      (visit[i]),
            .grant      (grant[i]),
            .queued     (pend[i]),
            .server     (srv_a[i]),
            .prio       (prio_a[i]),
            .saved      (saved_a[i]),
            .status     (stat_a[i])
        );
    end

    irqsrc_sweep #(.N(N)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rsnd_valid),
        .visit (visit)
    );

    irqsrc_arb #(
        .N(N), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .GNUM_W(GNUM_W), .BASE(BASE)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .srv_a      (srv_a),
        .prio_a     (prio_a),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req_num    (req_num),
        .req_server (req_server),
        .req_prio   (req_prio),
        .grant      (grant)
    );

    assign qry_server = srv_a[qry_idx];
    assign qry_prio   = prio_a[qry_idx];
    assign qry_saved  = saved_a[qry_idx];
    assign qry_status = stat_a[qry_idx];

    // R2: every offered number lies in this unit's range
    assert_num_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_num >= GNUM_W'(BASE) && req_num - GNUM_W'(BASE) < GNUM_W'(N)));
endmodule

// File: tb/tb_irqsrc_ctrl.sv
module tb_irqsrc_ctrl;
    localparam int N = 16;
    localparam int BASE = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [3:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic [7:0]  cfg_saved = '0;
    logic        rej_valid = 1'b0, eoi_valid = 1'b0, rsnd_valid = 1'b0;
    logic [15:0] rej_num = '0, eoi_num = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [15:0] req_num;
    logic [3:0]  req_server;
    logic [7:0]  req_prio;
    logic [3:0]  qry_idx = '0;
    logic [3:0]  qry_server;
    logic [7:0]  qry_prio, qry_saved;
    logic [3:0]  qry_status;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqsrc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .rsnd_valid(rsnd_valid),
        .req_valid(req_valid), .req_ready(req_ready), .req_num(req_num),
        .req_server(req_server), .req_prio(req_prio),
        .qry_idx(qry_idx), .qry_server(qry_server), .qry_prio(qry_prio),
        .qry_saved(qry_saved), .qry_status(qry_status)
    );

    task automatic chkeq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int srv, input int pr, input int sv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_server = 4'(srv);
        cfg_prio = 8'(pr); cfg_saved = 8'(sv);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_in(input int idx);
        @(negedge clk); src_in[idx] = 1'b1;
        @(negedge clk); src_in[idx] = 1'b0;
    endtask

    task automatic rej(input int num);
        @(negedge clk); rej_num = 16'(num); rej_valid = 1'b1;
        @(negedge clk); rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        @(negedge clk); eoi_num = 16'(num); eoi_valid = 1'b1;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic resend();
        @(negedge clk); rsnd_valid = 1'b1;
        @(negedge clk); rsnd_valid = 1'b0;
    endtask

    task automatic status_is(input string tag, input int idx, input int exp);
        qry_idx = 4'(idx); #1;
        chkeq(tag, 32'(qry_status), 32'(exp));
    endtask

    task automatic expect_req(input string tag, input int num, input int srv, input int pr);
        bit seen = 1'b0;
        for (int k = 0; k < 60 && !seen; k++) begin
            @(negedge clk);
            if (req_valid) seen = 1'b1;
        end
        chkeq({tag, " valid"}, 32'(seen), 1);
        if (seen) begin
            chkeq({tag, " num"}, 32'(req_num), 32'(num));
            chkeq({tag, " server"}, 32'(req_server), 32'(srv));
            chkeq({tag, " prio"}, 32'(req_prio), 32'(pr));
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
        end
    endtask

    task automatic expect_none(input string tag, input int n);
        bit bad = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (req_valid) bad = 1'b1;
        end
        chkeq(tag, 32'(bad), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every source
        for (int i = 0; i < N; i++) begin
            qry_idx = 4'(i); #1;
            chkeq("R1 prio", 32'(qry_prio), 32'hFF);
            chkeq("R1 saved", 32'(qry_saved), 32'hFF);
            chkeq("R1 server", 32'(qry_server), 0);
            chkeq("R1 status", 32'(qry_status), 0);
        end
        chkeq("R1 no request", 32'(req_valid), 0);

        // R4: masked message edge latches masked-pending
        pulse_in(6);
        expect_none("R4 masked edge silent", 8);
        status_is("R4 mpend set", 6, 8);
        // R5: unmasking write replays the message
        cfg(6, 2, 7, 9);
        expect_req("R5 unmask replay", BASE + 6, 2, 7);
        status_is("R5 mpend cleared", 6, 0);
        qry_idx = 4'd6; #1;
        chkeq("R5 saved stored", 32'(qry_saved), 9);

        // R13: write and edge in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd7; cfg_server = 4'd1; cfg_prio = 8'd4; cfg_saved = 8'd0;
        src_in[7] = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; src_in[7] = 1'b0;
        expect_req("R13 edge uses new prio", BASE + 7, 1, 4);
        status_is("R13 no mpend", 7, 0);

        // R2 R3: sweep over all message sources, input held high
        for (int i = 0; i < 8; i++) begin
            cfg(i, (i * 3) % 16, i + 1, 8'h40 + i);
            @(negedge clk); src_in[i] = 1'b1;
            expect_req("R2 R3 message request", BASE + i, (i * 3) % 16, i + 1);
            expect_none("R3 held input single request", 6);
            @(negedge clk); src_in[i] = 1'b0;
            qry_idx = 4'(i); #1;
            chkeq("R5 saved per source", 32'(qry_saved), 32'(8'h40 + i));
        end

        // R6: level sources, masked first then configured
        @(negedge clk); src_in[8] = 1'b1;
        expect_none("R6 masked level silent", 6);
        status_is("R6 asserted tracked", 8, 1);
        for (int i = 8; i < 16; i++) begin
            cfg(i, i - 8, i, 0);
            @(negedge clk); src_in[i] = 1'b1;
            expect_req("R6 R2 level request", BASE + i, i - 8, i);
            status_is("R6 sent and asserted", i, 3);
            expect_none("R6 no duplicate", 4);
        end

        // R7: level reject clears sent, no request; R9 sweep re-sends
        rej(BASE + 8);
        status_is("R7 level sent cleared", 8, 1);
        expect_none("R7 level reject silent", 6);
        resend();
        expect_req("R9 level resent by sweep", BASE + 8, 0, 8);
        expect_none("R9 sweep tail", 20);

        // R8: end-of-interrupt on level source
        eoi(BASE + 8);
        status_is("R8 level eoi clears sent", 8, 1);
        expect_none("R8 level eoi silent", 6);
        for (int i = 8; i < 16; i++) begin
            @(negedge clk); src_in[i] = 1'b0;
            eoi(BASE + i);
        end
        @(negedge clk);
        status_is("R6 deasserted", 9, 0);
        status_is("R6 deasserted", 8, 0);

        // R8: end-of-interrupt on message source has no effect
        eoi(BASE + 2);
        status_is("R8 message eoi no change", 2, 0);
        resend();
        expect_none("R8 message eoi no replay", 24);

        // R7 R9: message reject then sweep replay
        rej(BASE + 2);
        status_is("R7 message rejected", 2, 4);
        expect_none("R7 message reject silent", 4);
        resend();
        expect_req("R9 message replay", BASE + 2, 6, 3);
        status_is("R9 rejected cleared", 2, 0);
        expect_none("R9 sweep tail", 20);

        // R9: rejected but masked source is cleared without a request
        rej(BASE + 4);
        cfg(4, 12, 255, 0);
        resend();
        expect_none("R9 masked rejected silent", 24);
        status_is("R9 masked rejected cleared", 4, 0);

        // R11: lowest index first
        @(negedge clk); src_in[5] = 1'b1; src_in[2] = 1'b1;
        @(negedge clk); src_in[5] = 1'b0; src_in[2] = 1'b0;
        expect_req("R11 lowest first", BASE + 2, 6, 3);
        expect_req("R11 then next", BASE + 5, 15, 6);

        // R11: stalled request holds while a lower source queues
        pulse_in(3);
        begin
            bit seen = 1'b0;
            bit moved = 1'b0;
            for (int k = 0; k < 20 && !seen; k++) begin
                @(negedge clk);
                if (req_valid) seen = 1'b1;
            end
            chkeq("R11 stall valid", 32'(seen), 1);
            src_in[1] = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                src_in[1] = 1'b0;
                if (!req_valid || req_num != 16'(BASE + 3) || req_prio != 8'd4) moved = 1'b1;
            end
            chkeq("R11 held while stalled", 32'(moved), 0);
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
        end
        expect_req("R11 lower after stall", BASE + 1, 3, 2);

        // R12: reject lands in the cycle the sweep visits source 3
        @(negedge clk); rsnd_valid = 1'b1;
        @(negedge clk); rsnd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rej_num = 16'(BASE + 3); rej_valid = 1'b1;
        @(negedge clk); rej_valid = 1'b0;
        expect_none("R12 no replay on collision", 20);
        status_is("R12 rejected ends set", 3, 4);
        resend();
        expect_req("R12 next sweep replays", BASE + 3, 9, 4);
        expect_none("R12 sweep tail", 20);

        // R10: resend during a sweep forces another pass
        @(negedge clk); rsnd_valid = 1'b1;
        @(negedge clk); rsnd_valid = 1'b0;
        repeat (4) @(negedge clk);
        rej_num = 16'(BASE + 1); rej_valid = 1'b1; rsnd_valid = 1'b1;
        @(negedge clk); rej_valid = 1'b0; rsnd_valid = 1'b0;
        expect_req("R10 second pass replays", BASE + 1, 3, 2);
        expect_none("R10 sweep tail", 24);

        // R2: out-of-range notifications are ignored
        rej(BASE + 16);
        rej(BASE - 1);
        eoi(BASE + 16);
        for (int i = 0; i < N; i++) status_is("R2 out of range ignored", i, 0);
        expect_none("R2 out of range silent", 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule